// File: doc/BRIEF.md
# Key-Guarded System Configuration Register Block

This block is a small register file on a simple 32-bit register bus. One of its registers, the device configuration word, is guarded: a write to it only takes effect when the bus access just before it, to the guard register, carried the unlock key. Each unlock grants exactly one protected write. Any access to another register, or a write of a wrong value to the guard register, withdraws a pending unlock. Bus cycles with no access selected leave it in place.

Two bits of the configuration word drive outputs. Bit 23 gates an optional coprocessor: the `coprocEn` output follows it. Bit 31 is a software reset control. Software unlocks and sets the bit, then unlocks again and clears it. The falling edge of the stored bit gives a one-cycle `sysResetReq` pulse for the chip reset logic. Four more registers are ordinary read/write storage with no guard.

Top module: `syscfg_guard`

## Requirements
- R1: After reset every register reads 0, no unlock is pending, and `coprocEn` and `sysResetReq` are low.
- R2: A write of 0x000000AA to offset 0xC0 makes an unlock pending. A read of 0xC0 returns 1 in bit 0 while an unlock is pending and 0 otherwise, with all other bits 0. The read does not change the pending state.
- R3: A write to offset 0x80 while an unlock is pending replaces the configuration word and uses up the unlock, so a second write needs a new key.
- R4: A write to offset 0x80 with no pending unlock is discarded: the word read back and `coprocEn` are unchanged.
- R5: A write of any value other than 0x000000AA to offset 0xC0 withdraws a pending unlock.
- R6: Any selected access, read or write, to an offset other than 0xC0 withdraws a pending unlock. Cycles with `busSel` low keep it.
- R7: `coprocEn` is bit 23 of the stored configuration word. It changes in the cycle after the committing write.
- R8: `sysResetReq` is high for exactly one cycle, the cycle after a committed write that takes bit 31 of the configuration word from 1 to 0. It stays low for all other writes, including the write that sets bit 31.
- R9: Offsets 0x00, 0x04, 0x08 and 0x0C are plain registers. They are written and read back without any unlock.
- R10: A read of an unmapped offset returns 0, and a write to one changes no register. `busRdata` is 0 whenever no read is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Bus access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (8) | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational in the access cycle |
| coprocEn | output | 1 | Coprocessor access enable (configuration bit 23) |
| sysResetReq | output | 1 | One-cycle chip software reset request |

## Verification
Directed sequences cover the cases that tell apart which rule withdrew an unlock:
- the key followed directly by a configuration write,
- a wrong key in between,
- a plain-register access in between,
- a second write after a single key,
- idle cycles between key and write.

The reset sequence is run in two forms. The correct two-unlock form must give exactly one pulse. The set-only form must give none. A long random mix of reads, writes, keys, near-miss keys and unmapped offsets is then compared, cycle by cycle, with a bench model of the guard state and registers. This mix reaches orderings the directed cases do not.

// File: rtl/syscfg_pkg.sv
package syscfg_pkg;
  localparam int DATA_W     = 32;
  localparam int NUM_PLAIN  = 4;
  localparam int PLAIN_BASE = 'h00;
  localparam int PLAIN_STEP = 4;
  localparam int CFG_OFS    = 'h80;
  localparam int LOCK_OFS   = 'hC0;
  localparam logic [DATA_W-1:0] KEY_VALUE = 32'h0000_00AA;
  localparam int BIT_COPROC = 23;
  localparam int BIT_SWRST  = 31;

  // strobes from control to datapath
  typedef struct packed {
    logic                 cfgWr;
    logic [NUM_PLAIN-1:0] plainWr;
    logic                 rdEn;
    logic                 rdCfg;
    logic                 rdLock;
    logic [NUM_PLAIN-1:0] rdPlain;
  } cfg_strobe_t;
endpackage

// File: rtl/syscfg_ctrl.sv
module syscfg_ctrl
  import syscfg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output cfg_strobe_t       strobe,
  output logic              unlockPending
);
  logic hitLock, hitCfg, keyOk;
  logic [NUM_PLAIN-1:0] hitPlain;

  assign hitLock = (busAddr == ADDR_W'(LOCK_OFS));
  assign hitCfg  = (busAddr == ADDR_W'(CFG_OFS));
  assign keyOk   = (busWdata == KEY_VALUE);

  for (genvar i = 0; i < NUM_PLAIN; i++) begin : g_dec
    assign hitPlain[i] = (busAddr == ADDR_W'(PLAIN_BASE + PLAIN_STEP * i));
  end

  // one-shot write permission
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlockPending <= 1'b0;
    end else if (busSel) begin
      if (hitLock) begin
        if (busWr) unlockPending <= keyOk;
      end else begin
        unlockPending <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.cfgWr   = busSel && busWr && hitCfg && unlockPending;
    strobe.plainWr = (busSel && busWr) ? hitPlain : '0;
    strobe.rdEn    = busSel && !busWr;
    strobe.rdCfg   = hitCfg;
    strobe.rdLock  = hitLock;
    strobe.rdPlain = hitPlain;
  end
endmodule

// File: rtl/syscfg_dp.sv
module syscfg_dp
  import syscfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cfg_strobe_t       strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              unlockPending,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] cfgWord,
  output logic              coprocEn,
  output logic              sysResetReq
);
  logic [DATA_W-1:0] plainQ [NUM_PLAIN];
  logic [DATA_W-1:0] plainRd;

  for (genvar i = 0; i < NUM_PLAIN; i++) begin : g_plain
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   plainQ[i] <= '0;
      else if (strobe.plainWr[i]) plainQ[i] <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgWord     <= '0;
      sysResetReq <= 1'b0;
    end else begin
      sysResetReq <= strobe.cfgWr && cfgWord[BIT_SWRST] && !busWdata[BIT_SWRST];
      if (strobe.cfgWr) cfgWord <= busWdata;
    end
  end

  assign coprocEn = cfgWord[BIT_COPROC];

  always_comb begin
    plainRd = '0;
    for (int i = 0; i < NUM_PLAIN; i++)
      if (strobe.rdPlain[i]) plainRd = plainRd | plainQ[i];
  end

  always_comb begin
    busRdata = '0;
    if (strobe.rdEn) begin
      if (strobe.rdLock)     busRdata = {{(DATA_W-1){1'b0}}, unlockPending};
      else if (strobe.rdCfg) busRdata = cfgWord;
      else                   busRdata = plainRd;
    end
  end
endmodule

// File: rtl/syscfg_guard.sv
module syscfg_guard
  import syscfg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              coprocEn,
  output logic              sysResetReq
);
  cfg_strobe_t       strobe;
  logic              unlockPending;
  logic [DATA_W-1:0] cfgWord;

  syscfg_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata),
    .strobe(strobe), .unlockPending(unlockPending)
  );

  syscfg_dp i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .unlockPending(unlockPending), .busRdata(busRdata), .cfgWord(cfgWord),
    .coprocEn(coprocEn), .sysResetReq(sysResetReq)
  );
endmodule

// File: rtl/syscfg_guard_chk.sv
module syscfg_guard_chk
  import syscfg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              unlockPending,
  input logic              cfgCommit,
  input logic [31:0]       cfgWord,
  input logic              coprocEn,
  input logic              sysResetReq
);
  logic lockAcc, cfgAcc;
  assign lockAcc = busSel && (busAddr == ADDR_W'(LOCK_OFS));
  assign cfgAcc  = busSel && busWr && (busAddr == ADDR_W'(CFG_OFS));

  // R2
  key_arms_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockAcc && busWr && busWdata == KEY_VALUE |=> unlockPending);
  // R5
  bad_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockAcc && busWr && busWdata != KEY_VALUE |=> !unlockPending);
  // R6
  other_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !lockAcc |=> !unlockPending);
  // R3
  one_shot_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgAcc && unlockPending |=> !unlockPending && cfgWord == $past(busWdata));
  // R4
  locked_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgAcc && !unlockPending |=> $stable(cfgWord));
  // R7
  coproc_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(coprocEn) |-> $past(cfgCommit));
  // R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |=> !sysResetReq);
  // R8
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |-> $past(cfgCommit) && $fell(cfgWord[BIT_SWRST]));
endmodule

bind syscfg_guard syscfg_guard_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
  .busAddr(busAddr), .busWdata(busWdata), .unlockPending(unlockPending),
  .cfgCommit(strobe.cfgWr), .cfgWord(cfgWord), .coprocEn(coprocEn),
  .sysResetReq(sysResetReq)
);

// File: tb/test_syscfg_guard.sv
`timescale 1ns/100ps
module test_syscfg_guard;
  localparam int AW = 8;
  localparam logic [31:0] KEY = 32'h0000_00AA;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic coprocEn, sysResetReq;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  // bench model
  bit mPending;
  logic [31:0] mCfg;
  logic [31:0] mPlain [4];
  bit expPulse;

  always #2.5 clk = ~clk;

  syscfg_guard #(.ADDR_W(AW)) i_syscfg_guard (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .coprocEn(coprocEn), .sysResetReq(sysResetReq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [AW-1:0] a);
    case (a)
      8'hC0: return {31'b0, mPending};
      8'h80: return mCfg;
      8'h00: return mPlain[0];
      8'h04: return mPlain[1];
      8'h08: return mPlain[2];
      8'h0C: return mPlain[3];
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelResetState();
    mPending = 0; mCfg = '0; expPulse = 0;
    for (int i = 0; i < 4; i++) mPlain[i] = '0;
  endtask

  // one bus cycle: drive after the falling edge, check read data,
  // update model at the rising edge, check outputs after it
  task automatic doOp(input bit sel, input bit wr, input logic [AW-1:0] a,
                      input logic [31:0] d, input string tag);
    @(negedge clk);
    busSel = sel; busWr = wr; busAddr = a; busWdata = d;
    #1;
    if (sel && !wr) chk(busRdata == expRead(a), {tag, " read (R2 R9 R10)"}, busRdata, expRead(a));
    else            chk(busRdata == 32'h0, "R10 idle rdata", busRdata, 32'h0);
    @(posedge clk);
    expPulse = 0;
    if (sel) begin
      if (a == 8'hC0) begin
        if (wr) mPending = (d == KEY);
      end else begin
        if (wr && a == 8'h80 && mPending) begin
          expPulse = mCfg[31] && !d[31];
          mCfg = d;
        end
        if (wr) begin
          case (a)
            8'h00: mPlain[0] = d;
            8'h04: mPlain[1] = d;
            8'h08: mPlain[2] = d;
            8'h0C: mPlain[3] = d;
            default: ;
          endcase
        end
        mPending = 0;
      end
    end
    #1;
    chk(coprocEn == mCfg[23], {tag, " R7 coprocEn"}, {31'b0, coprocEn}, {31'b0, mCfg[23]});
    chk(sysResetReq == expPulse, {tag, " R8 sysResetReq"}, {31'b0, sysResetReq}, {31'b0, expPulse});
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    doOp(1, 1, a, d, tag);
  endtask
  task automatic rd(input logic [AW-1:0] a, input string tag);
    doOp(1, 0, a, 32'h0, tag);
  endtask
  task automatic idle(input string tag);
    doOp(0, 0, 8'h00, 32'h0, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [AW-1:0] addrs [7];
    modelResetState();
    repeat (3) @(posedge clk);
    #1;
    chk(coprocEn == 1'b0, "R1 coprocEn in reset", {31'b0, coprocEn}, 32'h0);
    chk(sysResetReq == 1'b0, "R1 sysResetReq in reset", {31'b0, sysResetReq}, 32'h0);
    @(negedge clk); rstN = 1'b1;

    // R1: everything reads zero
    rd(8'hC0, "R1"); rd(8'h80, "R1"); rd(8'h00, "R1"); rd(8'h0C, "R1");

    // R2: key arms, read of lock keeps it
    wr(8'hC0, KEY, "R2"); rd(8'hC0, "R2"); rd(8'hC0, "R2");
    // R3/R7: commit enables coprocessor
    wr(8'h80, 32'h0080_0000, "R3"); rd(8'hC0, "R3"); rd(8'h80, "R3");
    // R4: unguarded write discarded
    wr(8'h80, 32'h0000_0000, "R4"); rd(8'h80, "R4");
    // R3: second write after one key discarded
    wr(8'hC0, KEY, "R3"); wr(8'h80, 32'h0000_1234, "R3"); wr(8'h80, 32'h0000_0000, "R3"); rd(8'h80, "R3");
    // R5: wrong key withdraws unlock
    wr(8'hC0, KEY, "R5"); wr(8'hC0, 32'h0000_01AA, "R5"); rd(8'hC0, "R5"); wr(8'h80, 32'h5555_5555, "R5"); rd(8'h80, "R5");
    // R6: other access withdraws, idle keeps
    wr(8'hC0, KEY, "R6"); wr(8'h04, 32'hCAFE_0001, "R6"); wr(8'h80, 32'h0, "R6"); rd(8'h80, "R6");
    wr(8'hC0, KEY, "R6"); rd(8'h08, "R6"); rd(8'hC0, "R6");
    wr(8'hC0, KEY, "R6"); idle("R6"); idle("R6"); rd(8'hC0, "R6"); wr(8'h80, 32'h0000_0000, "R6");
    // R8: setting bit 31 gives no pulse, clearing it gives one
    wr(8'hC0, KEY, "R8"); wr(8'h80, 32'h8080_0000, "R8"); idle("R8");
    wr(8'hC0, KEY, "R8"); wr(8'h80, 32'h0080_0000, "R8"); idle("R8"); idle("R8");
    // R8: set-only sequence, and clearing without unlock gives no pulse
    wr(8'hC0, KEY, "R8"); wr(8'h80, 32'h8000_0000, "R8"); wr(8'h80, 32'h0, "R8"); idle("R8");
    wr(8'hC0, KEY, "R8"); wr(8'h80, 32'h0, "R8"); idle("R8");
    // R9: plain registers need no unlock
    wr(8'h00, 32'h1111_2222, "R9"); wr(8'h08, 32'hDEAD_BEEF, "R9"); wr(8'h0C, 32'hFFFF_FFFF, "R9");
    rd(8'h00, "R9"); rd(8'h04, "R9"); rd(8'h08, "R9"); rd(8'h0C, "R9");
    // R10: unmapped offsets
    wr(8'h40, 32'h7777_7777, "R10"); rd(8'h40, "R10"); rd(8'hC4, "R10"); rd(8'h00, "R10");

    // random mix
    addrs[0] = 8'h00; addrs[1] = 8'h04; addrs[2] = 8'h08; addrs[3] = 8'h0C;
    addrs[4] = 8'h80; addrs[5] = 8'hC0; addrs[6] = 8'h44;
    seed = $urandom(32'd1234);
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      logic [AW-1:0] a;
      logic [31:0] d;
      r = $urandom;
      a = (r[3:0] < 5) ? 8'hC0 : (r[3:0] < 10 ? 8'h80 : addrs[r[6:4] % 7]);
      d = $urandom;
      if (a == 8'hC0) d = (r[9:8] != 0) ? KEY : (r[10] ? (KEY ^ 32'h0000_0100) : d);
      if (a == 8'h80 && r[11]) d[31] = mCfg[31] ^ 1'b1;
      doOp(r[13:12] != 0, r[14] | r[15], a, d, "rand R3 R4 R5 R6");
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule